// File: doc/BRIEF.md
# Bus-Mastering Dual-Clock Word Mover

This block moves 32-bit words between a card-side data path and system memory. It is the master on a classic Wishbone bus. The card side runs on its own clock, `card_clk`. It hands words over through push and pop strobes into two clock-crossing queues. The bus side runs on `bus_clk`. It issues one single-word cycle at a time, at consecutive word addresses counted from `base_adr`.

Two enables choose the direction.

- With `rx_en` high, words that the card side pushes are written to memory.
- With `tx_en` high, words are read from memory and queued for the card side to pop.
- If both enables are high, receive is served and no reads are issued.

When the queue in use cannot supply a word, or has no room, no bus cycle starts. Dropping both enables rewinds the word index, so the next transfer begins again at the base address. Each queue reports full and empty in the domain that uses it.

Top module: `bus_fifo_filler`

## Requirements
- R1: While `rst` is high and after it falls, `m_cyc`, `m_stb`, `m_we`, `bus_full` and `crd_full` are 0, and `crd_empty` and `bus_empty` are 1, until traffic arrives.
- R2: With `rx_en` high, each word pushed on the card side is written on the bus once, in push order, with `m_we`=1. The n-th write since the last rewind uses address `base_adr + 4*n`.
- R3: With `tx_en` high, the block issues reads with `m_we`=0 at `base_adr + 4*n`. Each acknowledged read word is queued, and the card side pops the words in read order from `crd_dout`.
- R4: Once a cycle starts, `m_cyc`, `m_stb`, `m_we`, `m_adr` and `m_dat_o` stay unchanged until `m_ack` is sampled high, provided the enable for that direction stays high.
- R5: After every acknowledged cycle, `m_stb` and `m_cyc` are low for at least one bus clock.
- R6: In transmit mode, while `bus_full` is 1 no new bus cycle is started.
- R7: The receive queue holds 16 words. The 16th word that is pushed and not yet written raises `crd_full`. A push while `crd_full` is 1 is dropped and never reaches the bus.
- R8: If the enable for the direction of an unacknowledged cycle falls, `m_cyc`, `m_stb` and `m_we` are low after the next bus clock edge. In receive, the word stays queued and is written by the next cycle.
- R9: With both enables low, the word index returns to zero, so the next transfer uses `base_adr` again.
- R10: A pop while `crd_empty` is 1 is ignored and does not disturb the order of later words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | System bus clock |
| rst | input | 1 | Asynchronous reset, active high, both domains |
| card_clk | input | 1 | Card-side clock |
| rx_en | input | 1 | Receive enable: card words go to memory |
| tx_en | input | 1 | Transmit enable: memory words go to card side |
| base_adr | input | 32 | Byte address of the first word |
| m_adr | output | 32 | Bus address |
| m_we | output | 1 | Bus write enable |
| m_dat_o | output | 32 | Bus write data |
| m_dat_i | input | 32 | Bus read data |
| m_cyc | output | 1 | Bus cycle |
| m_stb | output | 1 | Bus strobe |
| m_ack | input | 1 | Bus acknowledge |
| crd_push | input | 1 | Card-side push strobe (receive queue) |
| crd_din | input | 32 | Card-side word to push |
| crd_pop | input | 1 | Card-side pop strobe (transmit queue) |
| crd_dout | output | 32 | Head word of the transmit queue |
| crd_full | output | 1 | Receive queue full, card domain |
| crd_empty | output | 1 | Transmit queue empty, card domain |
| bus_full | output | 1 | Transmit queue full, bus domain |
| bus_empty | output | 1 | Receive queue empty, bus domain |

## Verification
The bench uses the defaults: 32-bit data and address, 16-word queues (address width 4) and two synchronizer stages. The card clock runs at half the bus rate. Because the queues are shallow, a slave that never acknowledges fills the receive queue within sixteen pushes, and a fast slave fills the transmit queue within a few dozen clocks. That brings both full flags, the dropped extra push and the stall on a full queue into reach. Random wait states and random gaps between pushes and pops change the pointer crossings from one transfer to the next.

// File: rtl/filler_pkg.sv
package filler_pkg;
   typedef enum logic [1:0] {
      BM_IDLE  = 2'd0,
      BM_WRITE = 2'd1,
      BM_READ  = 2'd2
   } bm_state_e;
endpackage

// File: rtl/filler_gray_sync.sv
module filler_gray_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) chain[0] <= '0;
      else     chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
         if (rst) chain[s] <= '0;
         else     chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/filler_cdc_fifo.sv
module filler_cdc_fifo #(
   parameter int DATA_W      = 32,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              rst,
   input  logic              w_req,
   input  logic [DATA_W-1:0] w_data,
   output logic              w_full,
   input  logic              r_req,
   output logic [DATA_W-1:0] r_data,
   output logic              r_empty
);
   localparam int DEPTH = 1 << AW;
   localparam int PW    = AW + 1;

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return (b >> 1) ^ b;
   endfunction

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
   logic [PW-1:0] rgray_at_w, wgray_at_r;
   logic [PW-1:0] wbin_nx, wgray_nx, rbin_nx, rgray_nx;
   logic          w_do, r_do;

   // write domain
   assign w_do     = w_req && !w_full;
   assign wbin_nx  = wbin_q + {{AW{1'b0}}, w_do};
   assign wgray_nx = to_gray(wbin_nx);

   always_ff @(posedge wclk) begin
      if (w_do) mem[wbin_q[AW-1:0]] <= w_data;
   end

   always_ff @(posedge wclk or posedge rst) begin
      if (rst) begin
         wbin_q  <= '0;
         wgray_q <= '0;
         w_full  <= 1'b0;
      end else begin
         wbin_q  <= wbin_nx;
         wgray_q <= wgray_nx;
         w_full  <= (wgray_nx == {~rgray_at_w[PW-1:PW-2], rgray_at_w[PW-3:0]});
      end
   end

   // read domain
   assign r_do     = r_req && !r_empty;
   assign rbin_nx  = rbin_q + {{AW{1'b0}}, r_do};
   assign rgray_nx = to_gray(rbin_nx);
   assign r_data   = mem[rbin_q[AW-1:0]];

   always_ff @(posedge rclk or posedge rst) begin
      if (rst) begin
         rbin_q  <= '0;
         rgray_q <= '0;
         r_empty <= 1'b1;
      end else begin
         rbin_q  <= rbin_nx;
         rgray_q <= rgray_nx;
         r_empty <= (rgray_nx == wgray_at_r);
      end
   end

   filler_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_r2w (
      .clk (wclk), .rst (rst), .d (rgray_q), .q (rgray_at_w)
   );
   filler_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_w2r (
      .clk (rclk), .rst (rst), .d (wgray_q), .q (wgray_at_r)
   );

   // R7: the write pointer never moves while the queue is reported full
   p_full_holds_wptr_r7: assert property (@(posedge wclk) disable iff (rst)
      w_full |=> (wbin_q == $past(wbin_q)));
endmodule

// File: rtl/filler_bus_master.sv
module filler_bus_master
   import filler_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADR_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic [ADR_W-1:0]  base_adr,
   input  logic              rx_empty,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_pop,
   input  logic              tx_full,
   output logic              tx_push,
   output logic [DATA_W-1:0] tx_data,
   output logic [ADR_W-1:0]  m_adr,
   output logic              m_we,
   output logic [DATA_W-1:0] m_dat_o,
   input  logic [DATA_W-1:0] m_dat_i,
   output logic              m_cyc,
   output logic              m_stb,
   input  logic              m_ack
);
   localparam int IDX_W = ADR_W - 2;

   bm_state_e        state_q;
   logic [IDX_W-1:0] idx_q;
   logic [ADR_W-1:0] word_adr;
   logic             dir_live;

   assign word_adr = base_adr + {idx_q, 2'b00};
   assign dir_live = (state_q == BM_WRITE) ? rx_en : tx_en;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state_q <= BM_IDLE;
         idx_q   <= '0;
         m_cyc   <= 1'b0;
         m_stb   <= 1'b0;
         m_we    <= 1'b0;
         m_adr   <= '0;
         m_dat_o <= '0;
      end else begin
         unique case (state_q)
            BM_IDLE: begin
               if (!rx_en && !tx_en) begin
                  idx_q <= '0;
               end else if (rx_en) begin
                  if (!rx_empty) begin
                     state_q <= BM_WRITE;
                     m_cyc   <= 1'b1;
                     m_stb   <= 1'b1;
                     m_we    <= 1'b1;
                     m_adr   <= word_adr;
                     m_dat_o <= rx_data;
                  end
               end else if (!tx_full) begin
                  state_q <= BM_READ;
                  m_cyc   <= 1'b1;
                  m_stb   <= 1'b1;
                  m_we    <= 1'b0;
                  m_adr   <= word_adr;
               end
            end
            BM_WRITE, BM_READ: begin
               if (m_ack) begin
                  state_q <= BM_IDLE;
                  m_cyc   <= 1'b0;
                  m_stb   <= 1'b0;
                  m_we    <= 1'b0;
                  idx_q   <= idx_q + 1'b1;
               end else if (!dir_live) begin
                  state_q <= BM_IDLE;
                  m_cyc   <= 1'b0;
                  m_stb   <= 1'b0;
                  m_we    <= 1'b0;
               end
            end
            default: state_q <= BM_IDLE;
         endcase
      end
   end

   assign rx_pop  = (state_q == BM_WRITE) && m_ack;
   assign tx_push = (state_q == BM_READ) && m_ack;
   assign tx_data = m_dat_i;

   // R4: an open, unacknowledged cycle holds every bus output
   p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (rst)
      (m_stb && !m_ack && (m_we ? rx_en : tx_en)) |=>
      (m_stb && m_cyc && $stable(m_adr) && $stable(m_dat_o) && $stable(m_we)));

   // R5: strobe gap after each acknowledge
   p_gap_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
      (m_stb && m_ack) |=> (!m_stb && !m_cyc));

   // R6: no read cycle opens from idle while the transmit queue is full
   p_no_read_when_full_r6: assert property (@(posedge clk) disable iff (rst)
      (tx_full && !m_cyc) |=> !(m_cyc && !m_we));

   // R8: dropping both enables clears the bus within one clock
   p_quit_on_disable_r8: assert property (@(posedge clk) disable iff (rst)
      (!rx_en && !tx_en) |=> (!m_cyc && !m_stb && !m_we));
endmodule

// File: rtl/bus_fifo_filler.sv
module bus_fifo_filler #(
   parameter int DATA_W      = 32,
   parameter int ADR_W       = 32,
   parameter int FIFO_AW     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              rst,
   input  logic              card_clk,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic [ADR_W-1:0]  base_adr,
   output logic [ADR_W-1:0]  m_adr,
   output logic              m_we,
   output logic [DATA_W-1:0] m_dat_o,
   input  logic [DATA_W-1:0] m_dat_i,
   output logic              m_cyc,
   output logic              m_stb,
   input  logic              m_ack,
   input  logic              crd_push,
   input  logic [DATA_W-1:0] crd_din,
   input  logic              crd_pop,
   output logic [DATA_W-1:0] crd_dout,
   output logic              crd_full,
   output logic              crd_empty,
   output logic              bus_full,
   output logic              bus_empty
);
   if (FIFO_AW < 2) begin : g_bad_depth
      $error("FIFO_AW must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADR_W < 3) begin : g_bad_adr
      $error("ADR_W must be at least 3");
   end
   if ((DATA_W % 8) != 0) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes");
   end

   logic              rx_pop, tx_push;
   logic [DATA_W-1:0] rx_head, tx_word;

   filler_cdc_fifo #(.DATA_W(DATA_W), .AW(FIFO_AW), .SYNC_STAGES(SYNC_STAGES)) i_rx_q (
      .wclk    (card_clk),
      .rclk    (bus_clk),
      .rst     (rst),
      .w_req   (crd_push),
      .w_data  (crd_din),
      .w_full  (crd_full),
      .r_req   (rx_pop),
      .r_data  (rx_head),
      .r_empty (bus_empty)
   );

   filler_cdc_fifo #(.DATA_W(DATA_W), .AW(FIFO_AW), .SYNC_STAGES(SYNC_STAGES)) i_tx_q (
      .wclk    (bus_clk),
      .rclk    (card_clk),
      .rst     (rst),
      .w_req   (tx_push),
      .w_data  (tx_word),
      .w_full  (bus_full),
      .r_req   (crd_pop),
      .r_data  (crd_dout),
      .r_empty (crd_empty)
   );

   filler_bus_master #(.DATA_W(DATA_W), .ADR_W(ADR_W)) i_master (
      .clk      (bus_clk),
      .rst      (rst),
      .rx_en    (rx_en),
      .tx_en    (tx_en),
      .base_adr (base_adr),
      .rx_empty (bus_empty),
      .rx_data  (rx_head),
      .rx_pop   (rx_pop),
      .tx_full  (bus_full),
      .tx_push  (tx_push),
      .tx_data  (tx_word),
      .m_adr    (m_adr),
      .m_we     (m_we),
      .m_dat_o  (m_dat_o),
      .m_dat_i  (m_dat_i),
      .m_cyc    (m_cyc),
      .m_stb    (m_stb),
      .m_ack    (m_ack)
   );
endmodule

// File: tb/test_bus_fifo_filler.sv
module test_bus_fifo_filler;
   logic        bus_clk = 1'b0, card_clk = 1'b0, rst = 1'b1;
   logic        rx_en = 1'b0, tx_en = 1'b0;
   logic [31:0] base_adr = '0;
   logic [31:0] m_adr, m_dat_o, crd_dout;
   logic [31:0] m_dat_i = '0;
   logic        m_we, m_cyc, m_stb;
   logic        m_ack = 1'b0;
   logic        crd_push = 1'b0, crd_pop = 1'b0;
   logic [31:0] crd_din = '0;
   logic        crd_full, crd_empty, bus_full, bus_empty;

   always #4 bus_clk = ~bus_clk;
   always #8 card_clk = ~card_clk;

   bus_fifo_filler i_bus_fifo_filler (
      .bus_clk(bus_clk), .rst(rst), .card_clk(card_clk), .rx_en(rx_en), .tx_en(tx_en),
      .base_adr(base_adr), .m_adr(m_adr), .m_we(m_we), .m_dat_o(m_dat_o), .m_dat_i(m_dat_i),
      .m_cyc(m_cyc), .m_stb(m_stb), .m_ack(m_ack), .crd_push(crd_push), .crd_din(crd_din),
      .crd_pop(crd_pop), .crd_dout(crd_dout), .crd_full(crd_full), .crd_empty(crd_empty),
      .bus_full(bus_full), .bus_empty(bus_empty)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bus slave model with a log of every acknowledged cycle
   logic [31:0] log_adr [256];
   logic [31:0] log_dat [256];
   logic        log_we  [256];
   int          log_n = 0;
   int          slv_cnt = 0, slv_lim = 0, slv_wait_max = 0;
   logic        slv_hold = 1'b1;

   always @(posedge bus_clk) begin
      if (m_ack) begin
         m_ack <= 1'b0;
      end else if (m_cyc && m_stb && !slv_hold) begin
         if (slv_cnt >= slv_lim) begin
            logic [31:0] rv;
            rv = $urandom;
            m_ack            <= 1'b1;
            m_dat_i          <= rv;
            log_adr[log_n]   <= m_adr;
            log_we[log_n]    <= m_we;
            log_dat[log_n]   <= m_we ? m_dat_o : rv;
            log_n            <= log_n + 1;
            slv_cnt          <= 0;
            slv_lim          <= $urandom_range(slv_wait_max, 0);
         end else begin
            slv_cnt <= slv_cnt + 1;
         end
      end else begin
         slv_cnt <= 0;
      end
   end

   // R5 monitor: strobe must be low in the cycle after an acknowledge
   int gap_bad = 0, gap_seen = 0;
   logic ack_prev = 1'b0;
   always @(negedge bus_clk) begin
      if (ack_prev) begin
         gap_seen <= gap_seen + 1;
         if (m_stb || m_cyc) gap_bad <= gap_bad + 1;
      end
      ack_prev <= m_ack;
   end

   function automatic logic [31:0] exp_adr(input logic [31:0] b, input int n);
      return b + 32'(4 * n);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wait(input int n);
      repeat (n) @(negedge bus_clk);
   endtask

   task automatic push_word(input logic [31:0] d, input int gap);
      repeat (gap) @(negedge card_clk);
      @(negedge card_clk);
      crd_push = 1'b1;
      crd_din  = d;
      @(negedge card_clk);
      crd_push = 1'b0;
   endtask

   task automatic wait_log(input int target);
      for (int t = 0; t < 5000 && log_n < target; t++) @(negedge bus_clk);
      for (int t = 0; t < 5000 && m_cyc; t++) @(negedge bus_clk);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   logic [31:0] exp_w [64];
   int          l0, npop;
   logic [31:0] held_adr, held_dat;

   initial begin
      void'($urandom(32'h00c0ffee));
      bus_wait(3);
      // R1: during reset
      chk("R1 cyc in reset", {31'd0, m_cyc}, 32'd0);
      chk("R1 crd_empty in reset", {31'd0, crd_empty}, 32'd1);
      rst = 1'b0;
      bus_wait(4);
      chk("R1 cyc/stb/we", {29'd0, m_cyc, m_stb, m_we}, 32'd0);
      chk("R1 flags full", {30'd0, bus_full, crd_full}, 32'd0);
      chk("R1 flags empty", {30'd0, crd_empty, bus_empty}, 32'd3);

      // R2: receive run with random gaps and wait states
      slv_hold = 1'b0; slv_wait_max = 3;
      base_adr = 32'h1000_0000;
      rx_en = 1'b1;
      for (int i = 0; i < 24; i++) begin
         exp_w[i] = $urandom;
         push_word(exp_w[i], $urandom_range(3, 0));
      end
      wait_log(24);
      bus_wait(10);
      chk("R2 write count", 32'(log_n), 32'd24);
      for (int i = 0; i < 24; i++) begin
         chk("R2 write addr", log_adr[i], exp_adr(32'h1000_0000, i));
         chk("R2 write data", log_dat[i], exp_w[i]);
         chk("R2 write we", {31'd0, log_we[i]}, 32'd1);
      end
      chk("R2 queue drained", {31'd0, bus_empty}, 32'd1);
      rx_en = 1'b0;
      bus_wait(3);

      // R7 + R9: stalled slave fills the receive queue; rewind to new base
      slv_hold = 1'b1; slv_wait_max = 0;
      base_adr = 32'h2000_0040;
      rx_en = 1'b1;
      l0 = log_n;
      for (int i = 0; i < 16; i++) begin
         exp_w[i] = $urandom;
         push_word(exp_w[i], 0);
      end
      chk("R7 crd_full after 16", {31'd0, crd_full}, 32'd1);
      push_word(32'hdead_beef, 0);
      chk("R9 rewound address", m_adr, 32'h2000_0040);
      held_adr = m_adr; held_dat = m_dat_o;
      bus_wait(6);
      chk("R4 stb held", {30'd0, m_cyc, m_stb}, 32'd3);
      chk("R4 addr held", m_adr, held_adr);
      chk("R4 data held", m_dat_o, held_dat);
      slv_hold = 1'b0;
      wait_log(l0 + 16);
      bus_wait(40);
      chk("R7 dropped push not written", 32'(log_n - l0), 32'd16);
      for (int i = 0; i < 16; i++) begin
         chk("R7 drain data", log_dat[l0 + i], exp_w[i]);
         chk("R9 drain addr", log_adr[l0 + i], exp_adr(32'h2000_0040, i));
      end
      chk("R7 crd_full cleared", {31'd0, crd_full}, 32'd0);
      rx_en = 1'b0;
      bus_wait(3);

      // R8: abort of an unacknowledged write keeps the word
      slv_hold = 1'b1;
      base_adr = 32'h3000_0000;
      rx_en = 1'b1;
      exp_w[0] = $urandom;
      push_word(exp_w[0], 0);
      for (int t = 0; t < 200 && !m_cyc; t++) @(negedge bus_clk);
      chk("R8 cycle opened", {31'd0, m_cyc}, 32'd1);
      rx_en = 1'b0;
      @(negedge bus_clk);
      chk("R8 bus cleared", {29'd0, m_cyc, m_stb, m_we}, 32'd0);
      chk("R8 word kept", {31'd0, bus_empty}, 32'd0);
      l0 = log_n;
      slv_hold = 1'b0;
      rx_en = 1'b1;
      wait_log(l0 + 1);
      chk("R8 retried data", log_dat[l0], exp_w[0]);
      chk("R9 retried at base", log_adr[l0], 32'h3000_0000);
      rx_en = 1'b0;
      bus_wait(3);

      // R3 + R6 + R10: transmit run
      base_adr = 32'h4000_0100;
      slv_wait_max = 2;
      @(negedge card_clk); crd_pop = 1'b1;   // R10: pop on empty
      @(negedge card_clk); crd_pop = 1'b0;
      l0 = log_n;
      tx_en = 1'b1;
      for (int t = 0; t < 2000 && !bus_full; t++) @(negedge bus_clk);
      chk("R6 bus_full reached", {31'd0, bus_full}, 32'd1);
      chk("R6 reads at full", 32'(log_n - l0), 32'd16);
      for (int k = 0; k < 8; k++) begin
         @(negedge bus_clk);
         chk("R6 no cycle while full", {31'd0, m_cyc}, 32'd0);
      end
      npop = 0;
      for (int k = 0; k < 40; k++) begin
         repeat ($urandom_range(2, 0)) @(negedge card_clk);
         @(negedge card_clk);
         for (int t = 0; t < 500 && crd_empty; t++) @(negedge card_clk);
         if (npop == 0) chk("R10 first word after empty pop", crd_dout, log_dat[l0]);
         else           chk("R3 popped data", crd_dout, log_dat[l0 + npop]);
         crd_pop = 1'b1;
         @(negedge card_clk);
         crd_pop = 1'b0;
         npop++;
      end
      for (int t = 0; t < 500 && m_cyc; t++) @(negedge bus_clk);
      tx_en = 1'b0;
      bus_wait(20);
      while (!crd_empty && npop < 200) begin
         @(negedge card_clk);
         chk("R3 tail data", crd_dout, log_dat[l0 + npop]);
         crd_pop = 1'b1;
         @(negedge card_clk);
         crd_pop = 1'b0;
         npop++;
         repeat (4) @(negedge card_clk);
      end
      chk("R3 pops equal reads", 32'(npop), 32'(log_n - l0));
      for (int i = 0; i < log_n - l0; i++) begin
         chk("R3 read addr", log_adr[l0 + i], exp_adr(32'h4000_0100, i));
         chk("R3 read we", {31'd0, log_we[l0 + i]}, 32'd0);
      end

      chk("R5 acks observed", {31'd0, gap_seen > 0}, 32'd1);
      chk("R5 strobe gap violations", 32'(gap_bad), 32'd0);

      done = 1;
      finish_run();
   end
endmodule